// File: doc/BRIEF.md
# Integer Instruction Execute Unit

This block decodes one 32-bit instruction word from a three-operand, register-register, load/store style instruction subset and computes its result in a single combinational pass. The surrounding pipeline reads the two source registers and presents their values together with the instruction word. The block returns the value to write back, the index of the register to write, a write strobe, a signed-overflow flag and an illegal-instruction flag.

The register-register form selects its operation through a function field. The immediate forms carry a 16-bit constant. The unit covers wrapping add and subtract, bitwise AND, OR and NOR, logical shifts by a constant amount, signed set-on-less-than, and the immediate variants, including the form that loads the upper half of a word. Register storage, memory access and next-address logic belong to other blocks.

Top module: `exu_core`

## Requirements
- R1: The opcode sits in bits 31:26. Opcode 0 is the register-register form, and it writes the register named in bits 15:11. The immediate opcodes write the register named in bits 20:16. Bits 25:21 name the first source and bits 15:0 hold the immediate.
- R2: In the register-register form, function code 32 (bits 5:0) returns the wrapped sum rs_val_i + rt_val_i, and function code 34 returns the wrapped difference rs_val_i - rt_val_i.
- R3: ovf_o is 1 exactly when a register add (function 32), register subtract (function 34) or add-immediate (opcode 8) overflows as a signed two's-complement operation. When ovf_o is 1, wr_en_o is 0. No other operation raises ovf_o.
- R4: Function codes 36, 37 and 39 return rs AND rt, rs OR rt, and NOT(rs OR rt).
- R5: Function code 0 shifts rt_val_i left and function code 2 shifts it right logically (zero fill). The shift amount comes from bits 10:6. The value on rs_val_i has no effect on either shift.
- R6: Function code 42, and opcode 10 with its sign-extended immediate, return 1 when the first operand is less than the second in signed compare, and 0 otherwise.
- R7: Opcode 8 (add) and opcode 10 sign-extend the immediate. Opcode 12 (AND) and opcode 13 (OR) zero-extend it.
- R8: Opcode 15 returns the immediate in bits 31:16 with zeros in bits 15:0. The value on rs_val_i does not affect the result.
- R9: A legal instruction whose destination index is 0 still reports its result and destination, but wr_en_o is 0.
- R10: Any other opcode, and any function code under opcode 0 that is not listed above, sets illegal_o to 1. In that case result_o, dest_o, wr_en_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of the first source register |
| rt_val_i | input | DATA_W | Value of the second source register |
| result_o | output | DATA_W | Value to write back |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back strobe |
| ovf_o | output | 1 | Signed overflow on the add and subtract forms |
| illegal_o | output | 1 | Undefined opcode or function code |

## Verification
Overflow is the hardest case to reach from the ports. It needs operand pairs that sit right at the signed limits. The add case needs two operands with the same sign and the subtract case needs two operands with opposite signs. The add-immediate case also needs the immediate's sign bit to carry the sum across the limit. The stimulus drives each of these pairs directly. It also drives near-miss pairs that do not overflow, such as adding -1 to -1. These confirm that the flag tracks the sign rule and not merely large magnitudes. A destination of 0 is combined with a result that would otherwise be written, so that write suppression is observed on its own, apart from overflow.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSN_W  = 32;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int RIDX_W  = 5;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;

  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int SH_LSB  = 6;

  localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI  = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL = 6'd2;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_NOR,
    ALU_SLT,
    ALU_SLL,
    ALU_SRL,
    ALU_LUI
  } alu_fn_e;

  typedef struct packed {
    logic    legal;
    alu_fn_e fn;
    logic    use_imm;
    logic    imm_signed;
    logic    dest_is_rd;
    logic    chk_ovf;
  } exu_ctl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output exu_ctl_t        ctl_o
);

  always_comb begin
    ctl_o            = '0;
    ctl_o.fn         = ALU_ADD;
    unique case (op_i)
      OPC_REG: begin
        ctl_o.legal      = 1'b1;
        ctl_o.dest_is_rd = 1'b1;
        unique case (fn_i)
          FN_ADD: begin ctl_o.fn = ALU_ADD; ctl_o.chk_ovf = 1'b1; end
          FN_SUB: begin ctl_o.fn = ALU_SUB; ctl_o.chk_ovf = 1'b1; end
          FN_AND: ctl_o.fn = ALU_AND;
          FN_OR:  ctl_o.fn = ALU_OR;
          FN_NOR: ctl_o.fn = ALU_NOR;
          FN_SLT: ctl_o.fn = ALU_SLT;
          FN_SLL: ctl_o.fn = ALU_SLL;
          FN_SRL: ctl_o.fn = ALU_SRL;
          default: ctl_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctl_o.legal      = 1'b1;
        ctl_o.fn         = ALU_ADD;
        ctl_o.use_imm    = 1'b1;
        ctl_o.imm_signed = 1'b1;
        ctl_o.chk_ovf    = 1'b1;
      end
      OPC_SLTI: begin
        ctl_o.legal      = 1'b1;
        ctl_o.fn         = ALU_SLT;
        ctl_o.use_imm    = 1'b1;
        ctl_o.imm_signed = 1'b1;
      end
      OPC_ANDI: begin
        ctl_o.legal   = 1'b1;
        ctl_o.fn      = ALU_AND;
        ctl_o.use_imm = 1'b1;
      end
      OPC_ORI: begin
        ctl_o.legal   = 1'b1;
        ctl_o.fn      = ALU_OR;
        ctl_o.use_imm = 1'b1;
      end
      OPC_LUI: begin
        ctl_o.legal   = 1'b1;
        ctl_o.fn      = ALU_LUI;
        ctl_o.use_imm = 1'b1;
      end
      default: ctl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]  val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  output logic [DATA_W-1:0]  val_o
);

  logic [DATA_W-1:0] stg [SHAMT_W+1];

  assign stg[0] = val_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    always_comb begin
      if (!amt_i[s]) begin
        stg[s+1] = stg[s];
      end else if (left_i) begin
        stg[s+1] = stg[s] << DIST;
      end else begin
        stg[s+1] = stg[s] >> DIST;
      end
    end
  end

  assign val_o = stg[SHAMT_W];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e            fn_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [DATA_W-1:0]  sh_src_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  y_o,
  output logic               ovf_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] shifted;
  logic              add_ovf;
  logic              sub_ovf;
  logic              lt_signed;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;

  assign add_ovf   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign sub_ovf   = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
  assign lt_signed = $signed(a_i) < $signed(b_i);

  exu_shift #(.DATA_W(DATA_W)) u_shift (
    .val_i  (sh_src_i),
    .amt_i  (shamt_i),
    .left_i (fn_i == ALU_SLL),
    .val_o  (shifted)
  );

  always_comb begin
    y_o   = '0;
    ovf_o = 1'b0;
    unique case (fn_i)
      ALU_ADD: begin y_o = sum;  ovf_o = add_ovf; end
      ALU_SUB: begin y_o = diff; ovf_o = sub_ovf; end
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLT: y_o = {{(DATA_W-1){1'b0}}, lt_signed};
      ALU_SLL: y_o = shifted;
      ALU_SRL: y_o = shifted;
      ALU_LUI: y_o = b_i << IMM_W;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSN_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              wr_en_o,
  output logic              ovf_o,
  output logic              illegal_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [OP_W-1:0]    op;
  logic [FN_W-1:0]    fn;
  logic [RIDX_W-1:0]  rt_idx;
  logic [RIDX_W-1:0]  rd_idx;
  logic [SHAMT_W-1:0] shamt;
  logic [IMM_W-1:0]   imm;
  logic               rs_idx_unused;

  exu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic              alu_ovf;
  logic [RIDX_W-1:0] dest_sel;
  logic              ovf_hit;

  assign op            = instr_i[OP_LSB +: OP_W];
  assign fn            = instr_i[0 +: FN_W];
  assign rt_idx        = instr_i[RT_LSB +: RIDX_W];
  assign rd_idx        = instr_i[RD_LSB +: RIDX_W];
  assign shamt         = instr_i[SH_LSB +: SHAMT_W];
  assign imm           = instr_i[0 +: IMM_W];
  assign rs_idx_unused = ^instr_i[RS_LSB +: RIDX_W];

  exu_decode u_decode (
    .op_i  (op),
    .fn_i  (fn),
    .ctl_o (ctl)
  );

  assign imm_ext = ctl.imm_signed ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                  : {{EXT_W{1'b0}}, imm};
  assign opnd_b  = ctl.use_imm ? imm_ext : rt_val_i;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i     (ctl.fn),
    .a_i      (rs_val_i),
    .b_i      (opnd_b),
    .sh_src_i (rt_val_i),
    .shamt_i  (shamt),
    .y_o      (alu_y),
    .ovf_o    (alu_ovf)
  );

  assign dest_sel = ctl.dest_is_rd ? rd_idx : rt_idx;
  assign ovf_hit  = ctl.legal && ctl.chk_ovf && alu_ovf;

  assign result_o  = ctl.legal ? alu_y : '0;
  assign dest_o    = ctl.legal ? dest_sel : '0;
  assign ovf_o     = ovf_hit;
  assign illegal_o = !ctl.legal;
  assign wr_en_o   = ctl.legal && !ovf_hit && (dest_sel != '0);

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [INSN_W-1:0] instr_i,
  input logic [DATA_W-1:0] result_o,
  input logic [RIDX_W-1:0] dest_o,
  input logic              wr_en_o,
  input logic              ovf_o,
  input logic              illegal_o
);

  logic [OP_W-1:0] c_op;
  logic [FN_W-1:0] c_fn;
  logic            c_arith;
  logic            c_cmp;

  assign c_op    = instr_i[OP_LSB +: OP_W];
  assign c_fn    = instr_i[0 +: FN_W];
  assign c_arith = (c_op == OPC_ADDI) ||
                   ((c_op == OPC_REG) && ((c_fn == FN_ADD) || (c_fn == FN_SUB)));
  assign c_cmp   = (c_op == OPC_SLTI) || ((c_op == OPC_REG) && (c_fn == FN_SLT));

  always_comb begin
    a_r3_ovf_blocks_write: assert (!(ovf_o && wr_en_o))
      else $error("overflow with write enabled");
    a_r3_ovf_only_arith: assert (!ovf_o || c_arith)
      else $error("overflow on non-arithmetic op");
    a_r9_zero_dest_no_write: assert (!(wr_en_o && dest_o == '0))
      else $error("write to index 0");
    a_r10_illegal_quiet: assert (!illegal_o ||
                                 (!wr_en_o && !ovf_o && result_o == '0 && dest_o == '0))
      else $error("illegal instruction not quiet");
    a_r6_cmp_is_bool: assert (!c_cmp || illegal_o || result_o[DATA_W-1:1] == '0)
      else $error("compare result wider than one bit");
    a_r8_lui_low_zero: assert (c_op != OPC_LUI || result_o[IMM_W-1:0] == '0)
      else $error("upper-immediate low half not zero");
    a_r1_dest_field: assert (illegal_o ||
                             dest_o == ((c_op == OPC_REG) ? instr_i[RD_LSB +: RIDX_W]
                                                          : instr_i[RT_LSB +: RIDX_W]))
      else $error("destination field mismatch");
  end

endmodule

bind exu_core exu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .instr_i   (instr_i),
  .result_o  (result_o),
  .dest_o    (dest_o),
  .wr_en_o   (wr_en_o),
  .ovf_o     (ovf_o),
  .illegal_o (illegal_o)
);

// File: tb/exu_core_bench.sv
module exu_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en;
  logic        ovf;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  exu_core u_exu_core (
    .instr_i   (instr),
    .rs_val_i  (rs_val),
    .rt_val_i  (rt_val),
    .result_o  (result),
    .dest_o    (dest),
    .wr_en_o   (wr_en),
    .ovf_o     (ovf),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rw(input int rs, input int rt, input int rd,
                                     input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] iw(input int op, input int rs, input int rt,
                                     input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  task automatic run(input string tag, input logic [31:0] w,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] e_res, input logic [4:0] e_dst,
                     input logic e_wr, input logic e_ovf, input logic e_ill);
    @(negedge clk);
    instr  = w;
    rs_val = a;
    rt_val = b;
    @(posedge clk);
    #1;
    n_checks++;
    if (result !== e_res || dest !== e_dst || wr_en !== e_wr ||
        ovf !== e_ovf || illegal !== e_ill) begin
      n_fail++;
      $display("FAIL %s: got res=%h dst=%0d wr=%b ovf=%b ill=%b exp res=%h dst=%0d wr=%b ovf=%b ill=%b",
               tag, result, dest, wr_en, ovf, illegal,
               e_res, e_dst, e_wr, e_ovf, e_ill);
    end
  endtask

  task automatic t_idle();
    run("R5 idle word zero", 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 0, 0, 0);
  endtask

  task automatic t_arith();
    run("R1 R2 add to rd", rw(17, 18, 9, 0, 32), 32'd5, 32'd7, 32'd12, 5'd9, 1, 0, 0);
    run("R2 sub negative", rw(1, 2, 3, 0, 34), 32'd5, 32'd7, 32'hFFFF_FFFE, 5'd3, 1, 0, 0);
  endtask

  task automatic t_ovf();
    run("R3 add pos ovf", rw(1, 2, 4, 0, 32), 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 5'd4, 0, 1, 0);
    run("R3 sub neg ovf", rw(1, 2, 4, 0, 34), 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 5'd4, 0, 1, 0);
    run("R3 sub mixed ovf", rw(1, 2, 4, 0, 34), 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 5'd4, 0, 1, 0);
    run("R3 addi ovf", iw(8, 1, 6, 16'h0001), 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 5'd6, 0, 1, 0);
    run("R3 R7 addi neg no ovf", iw(8, 1, 6, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFE, 5'd6, 1, 0, 0);
    run("R3 add neg no ovf", rw(1, 2, 4, 0, 32), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 5'd4, 1, 0, 0);
    run("R3 or never ovf", rw(1, 2, 4, 0, 37), 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 5'd4, 1, 0, 0);
  endtask

  task automatic t_logic();
    run("R4 and", rw(1, 2, 5, 0, 36), 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 5'd5, 1, 0, 0);
    run("R4 or",  rw(1, 2, 5, 0, 37), 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 5'd5, 1, 0, 0);
    run("R4 nor", rw(1, 2, 5, 0, 39), 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h000F_F000, 5'd5, 1, 0, 0);
  endtask

  task automatic t_shift();
    run("R5 sll 31 rs ignored", rw(0, 2, 7, 31, 0), 32'hDEAD_BEEF, 32'h1, 32'h8000_0000, 5'd7, 1, 0, 0);
    run("R5 srl 4 zero fill", rw(0, 2, 7, 4, 2), 32'h1234_5678, 32'h8000_0000, 32'h0800_0000, 5'd7, 1, 0, 0);
    run("R5 srl 0 passes", rw(0, 2, 7, 0, 2), 32'hFFFF_FFFF, 32'hA5A5_0003, 32'hA5A5_0003, 5'd7, 1, 0, 0);
    run("R5 sll 5 mixed", rw(0, 2, 7, 5, 0), 32'h0, 32'h0800_0003, 32'h0000_0060, 5'd7, 1, 0, 0);
  endtask

  task automatic t_cmp();
    run("R6 slt neg lt pos", rw(1, 2, 8, 0, 42), 32'hFFFF_FFFF, 32'h1, 32'h1, 5'd8, 1, 0, 0);
    run("R6 slt pos vs neg", rw(1, 2, 8, 0, 42), 32'h1, 32'hFFFF_FFFF, 32'h0, 5'd8, 1, 0, 0);
    run("R6 slt equal", rw(1, 2, 8, 0, 42), 32'h42, 32'h42, 32'h0, 5'd8, 1, 0, 0);
    run("R6 R7 slti sext", iw(10, 1, 8, 16'hFFFC), 32'hFFFF_FFFB, 32'h0, 32'h1, 5'd8, 1, 0, 0);
    run("R6 R7 slti large pos", iw(10, 1, 8, 16'h8000), 32'h0000_0001, 32'h0, 32'h0, 5'd8, 1, 0, 0);
  endtask

  task automatic t_imm();
    run("R7 andi zext", iw(12, 1, 10, 16'h8001), 32'hFFFF_FFFF, 32'h0, 32'h0000_8001, 5'd10, 1, 0, 0);
    run("R7 ori zext", iw(13, 1, 10, 16'h8000), 32'h1234_0000, 32'h0, 32'h1234_8000, 5'd10, 1, 0, 0);
    run("R7 addi sext wrap", iw(8, 1, 10, 16'hFFF0), 32'h0000_0010, 32'h0, 32'h0, 5'd10, 1, 0, 0);
  endtask

  task automatic t_lui();
    run("R8 lui rs ignored", iw(15, 9, 11, 16'h00FF), 32'hCAFE_F00D, 32'h1, 32'h00FF_0000, 5'd11, 1, 0, 0);
    run("R8 lui top bit", iw(15, 0, 11, 16'h8001), 32'h0, 32'h0, 32'h8001_0000, 5'd11, 1, 0, 0);
  endtask

  task automatic t_zero_dest();
    run("R9 add to index 0", rw(1, 2, 0, 0, 32), 32'd5, 32'd7, 32'd12, 5'd0, 0, 0, 0);
    run("R9 ori to index 0", iw(13, 1, 0, 16'h0F0F), 32'h0, 32'h0, 32'h0000_0F0F, 5'd0, 0, 0, 0);
  endtask

  task automatic t_illegal();
    run("R10 opcode 2", iw(2, 1, 2, 16'h1234), 32'h7FFF_FFFF, 32'h1, 32'h0, 5'd0, 0, 0, 1);
    run("R10 opcode 35", iw(35, 1, 2, 16'h0004), 32'h1, 32'h1, 32'h0, 5'd0, 0, 0, 1);
    run("R10 funct 8", rw(31, 0, 3, 0, 8), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 5'd0, 0, 0, 1);
    run("R10 funct 33", rw(1, 2, 3, 0, 33), 32'h7FFF_FFFF, 32'h1, 32'h0, 5'd0, 0, 0, 1);
  endtask

  initial begin
    instr  = 32'h0;
    rs_val = 32'h0;
    rt_val = 32'h0;
    t_idle();
    t_arith();
    t_ovf();
    t_logic();
    t_shift();
    t_cmp();
    t_imm();
    t_lui();
    t_zero_dest();
    t_illegal();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule